// File: doc/BRIEF.md
# Entry-Keyed Exit Predictor

This block guesses how a straight-line code region will be left. It does not look up the address of the instruction that performs the transfer. It looks up the address at which control arrived in the region. Each prediction gives a target address, the cycle inside the region at which the taken exit fires, and whether the exit is a branch, a call or a return. The predictor simply repeats whatever outcome was last resolved for the same key, even when the original transfer was computed at run time.

Call and return pairs are handled with a small return stack owned by the predictor. A predicted call pushes the continuation point recorded for it. A predicted return carries no stored address: it takes the newest stack entry and removes it. An optional history mode builds the key from a running hash of recent entry addresses, so the same region can predict different exits depending on how it was reached. When the pipeline reports a wrong guess, it hands back a stack checkpoint that was issued with the prediction. The stack is rewound to that checkpoint before the corrected outcome is applied.

Top module: `entry_exit_pred`

## Requirements
- R1: While `rst` or `flush` is high, all entries become invalid, the history hash is cleared and the return stack is emptied. In the next cycle `pred_valid` is 0, and any lookup or update presented in a flush cycle is dropped.
- R2: A lookup presented at one clock edge produces its result at the second following edge. `pred_valid` is 0 after the first edge.
- R3: In direct mode (`hist_mode`=0) the key equals `lk_entry`. Its low IDX_W bits pick one of 2^IDX_W slots and the remaining bits are the tag. A tag mismatch, or a slot never written, gives `pred_valid`=0.
- R4: An update writes target, link, cycle and kind at `upd_key`, replacing the slot's previous contents. A later lookup of that key repeats exactly the newest outcome.
- R5: The kind is encoded 0 = branch, 1 = call, 2 = return. A branch or call hit reports the stored target, cycle and kind, and `pred_key` carries the key that was looked up.
- R6: A call hit pushes the entry's stored link value onto the return stack.
- R7: A return hit reports the newest stack value as target and pops it. On an empty stack it reports `pred_valid`=0 and the stack is left unchanged.
- R8: The stack holds RAS_DEPTH (8) values. A push on a full stack discards the oldest value, so after 9 calls only 8 returns are predicted, newest first.
- R9: In history mode the key is `lk_entry ^ (H << 2)`. The register H is loaded with that same value on every accepted lookup in either mode, and flush clears it.
- R10: An update with `upd_mispred`=1 first restores the stack pointer and occupancy from `upd_snap_ptr`/`upd_snap_cnt`. It then applies the corrected kind: a call pushes `upd_link`, a return pops. The lookup in flight in that cycle produces no prediction.
- R11: When a lookup and an update hit the same slot in one cycle, the lookup sees the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate table, history and stack |
| lk_valid | input | 1 | Lookup request |
| lk_entry | input | ADDR_W | Address at which the region was entered |
| hist_mode | input | 1 | 1 = key from history hash |
| upd_valid | input | 1 | Resolved outcome present |
| upd_key | input | ADDR_W | Key returned from the prediction |
| upd_target | input | ADDR_W | Resolved target |
| upd_link | input | ADDR_W | Continuation pushed when kind is call |
| upd_cycle | input | CYC_W | Exit cycle within the region |
| upd_kind | input | 2 | 0 branch, 1 call, 2 return |
| upd_mispred | input | 1 | Outcome corrects a wrong prediction |
| upd_snap_ptr | input | log2(RAS_DEPTH) | Stack pointer checkpoint |
| upd_snap_cnt | input | log2(RAS_DEPTH+1) | Stack occupancy checkpoint |
| pred_valid | output | 1 | Prediction present |
| pred_target | output | ADDR_W | Predicted target |
| pred_cycle | output | CYC_W | Predicted exit cycle |
| pred_kind | output | 2 | Predicted transfer kind |
| pred_key | output | ADDR_W | Key used for this prediction |
| pred_snap_ptr | output | log2(RAS_DEPTH) | Stack pointer before this prediction |
| pred_snap_cnt | output | log2(RAS_DEPTH+1) | Stack occupancy before this prediction |

## Verification
Several properties are checked on every clock. Flush silences the output and sets the table valid bits to zero. A prediction never appears without a lookup two edges earlier. A predicted return never comes from an empty checkpoint. Stack occupancy stays in bounds, grows by one on a push, and is restored exactly from a checkpoint. Only the bench scenarios can show that the right values come out. These cover tag aliasing, overwrite by a newer outcome, the newest-first return order after an overflow, the XOR-shift chain reaching a slot the direct key would not reach, the squash of the lookup in flight, and the read-before-write result of a colliding update.

// File: rtl/exitp_pkg.sv
package exitp_pkg;
  typedef enum logic [1:0] {
    XK_BRANCH = 2'd0,
    XK_CALL   = 2'd1,
    XK_RETURN = 2'd2,
    XK_RSVD   = 2'd3
  } xkind_e;
endpackage

// File: rtl/exitp_hist.sv
module exitp_hist #(
  parameter int ADDR_W = 32,
  parameter int SHIFT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              lk_valid,
  input  logic              hist_mode,
  input  logic [ADDR_W-1:0] entry,
  output logic [ADDR_W-1:0] key
);
  logic [ADDR_W-1:0] hist;
  logic [ADDR_W-1:0] chain;

  always_comb begin
    chain = entry ^ (hist << SHIFT);
    key   = hist_mode ? chain : entry;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) hist <= '0;
    else if (lk_valid) hist <= chain;
  end

  // R9
  hist_flush_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> hist == '0);
endmodule

// File: rtl/exitp_table.sv
module exitp_table #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int CYC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_key,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_key,
  input  logic [ADDR_W-1:0] wr_target,
  input  logic [ADDR_W-1:0] wr_link,
  input  logic [CYC_W-1:0]  wr_cycle,
  input  logic [1:0]        wr_kind,
  output logic              rd_hit,
  output logic [ADDR_W-1:0] rd_target,
  output logic [ADDR_W-1:0] rd_link,
  output logic [CYC_W-1:0]  rd_cycle,
  output logic [1:0]        rd_kind
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] link;
    logic [CYC_W-1:0]  cyc;
    logic [1:0]        kind;
  } slot_t;

  slot_t             mem [DEPTH];
  logic [DEPTH-1:0]  vld;
  slot_t             q_slot;
  logic              q_vld;
  logic [TAG_W-1:0]  q_tag;
  logic [IDX_W-1:0]  r_idx, w_idx;
  slot_t             w_slot;

  always_comb begin
    r_idx  = rd_key[IDX_W-1:0];
    w_idx  = wr_key[IDX_W-1:0];
    w_slot = '{tag: wr_key[ADDR_W-1:IDX_W], target: wr_target,
               link: wr_link, cyc: wr_cycle, kind: wr_kind};
  end

  // data array: plain synchronous write, read-first synchronous read
  always_ff @(posedge clk) begin
    if (wr_en) mem[w_idx] <= w_slot;
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      q_slot <= mem[r_idx];
      q_vld  <= vld[r_idx];
      q_tag  <= rd_key[ADDR_W-1:IDX_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) vld <= '0;
    else if (wr_en) vld[w_idx] <= 1'b1;
  end

  always_comb begin
    rd_hit    = q_vld && (q_slot.tag == q_tag);
    rd_target = q_slot.target;
    rd_link   = q_slot.link;
    rd_cycle  = q_slot.cyc;
    rd_kind   = q_slot.kind;
  end

  // R1
  tab_flush_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> vld == '0);
  // R4
  tab_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && !flush |=> vld[$past(w_idx)]);
endmodule

// File: rtl/exitp_ras.sv
module exitp_ras #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               push_val,
  input  logic                       restore,
  input  logic [$clog2(DEPTH)-1:0]   snap_ptr,
  input  logic [$clog2(DEPTH+1)-1:0] snap_cnt,
  output logic [W-1:0]               top,
  output logic [$clog2(DEPTH)-1:0]   ptr,
  output logic [$clog2(DEPTH+1)-1:0] cnt
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] base_ptr, top_idx;
  logic [CNT_W-1:0] base_cnt;

  always_comb begin
    base_ptr = restore ? snap_ptr : ptr;
    base_cnt = restore ? snap_cnt : cnt;
    top_idx  = ptr - PTR_W'(1);
    top      = mem[top_idx];
  end

  // ring storage: oldest slot is overwritten when full
  always_ff @(posedge clk) begin
    if (push && !clear) mem[base_ptr] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ptr <= '0;
      cnt <= '0;
    end else if (push) begin
      ptr <= base_ptr + PTR_W'(1);
      cnt <= (base_cnt == CNT_W'(DEPTH)) ? base_cnt : base_cnt + CNT_W'(1);
    end else if (pop && base_cnt != '0) begin
      ptr <= base_ptr - PTR_W'(1);
      cnt <= base_cnt - CNT_W'(1);
    end else begin
      ptr <= base_ptr;
      cnt <= base_cnt;
    end
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));
  // R6
  push_grow_chk: assert property (@(posedge clk) disable iff (rst)
    push && !restore && !clear && (cnt != CNT_W'(DEPTH)) |=> cnt == CNT_W'($past(cnt) + 1'b1));
  // R10
  restore_chk: assert property (@(posedge clk) disable iff (rst)
    restore && !push && !pop && !clear |=> (cnt == $past(snap_cnt)) && (ptr == $past(snap_ptr)));
endmodule

// File: rtl/entry_exit_pred.sv
module entry_exit_pred
  import exitp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 6,
  parameter int CYC_W     = 4,
  parameter int RAS_DEPTH = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           flush,
  input  logic                           lk_valid,
  input  logic [ADDR_W-1:0]              lk_entry,
  input  logic                           hist_mode,
  input  logic                           upd_valid,
  input  logic [ADDR_W-1:0]              upd_key,
  input  logic [ADDR_W-1:0]              upd_target,
  input  logic [ADDR_W-1:0]              upd_link,
  input  logic [CYC_W-1:0]               upd_cycle,
  input  logic [1:0]                     upd_kind,
  input  logic                           upd_mispred,
  input  logic [$clog2(RAS_DEPTH)-1:0]   upd_snap_ptr,
  input  logic [$clog2(RAS_DEPTH+1)-1:0] upd_snap_cnt,
  output logic                           pred_valid,
  output logic [ADDR_W-1:0]              pred_target,
  output logic [CYC_W-1:0]               pred_cycle,
  output logic [1:0]                     pred_kind,
  output logic [ADDR_W-1:0]              pred_key,
  output logic [$clog2(RAS_DEPTH)-1:0]   pred_snap_ptr,
  output logic [$clog2(RAS_DEPTH+1)-1:0] pred_snap_cnt
);
  localparam int PTR_W = $clog2(RAS_DEPTH);
  localparam int CNT_W = $clog2(RAS_DEPTH+1);

  logic [ADDR_W-1:0] lk_key, s1_key;
  logic              s1_v;
  logic              t_hit;
  logic [ADDR_W-1:0] t_target, t_link;
  logic [CYC_W-1:0]  t_cycle;
  logic [1:0]        t_kind;
  logic [ADDR_W-1:0] r_top;
  logic [PTR_W-1:0]  r_ptr;
  logic [CNT_W-1:0]  r_cnt;
  logic              mis, hit, pv, s2_push, s2_pop;
  logic              r_push, r_pop;
  logic [ADDR_W-1:0] r_val;

  exitp_hist #(.ADDR_W(ADDR_W), .SHIFT(2)) u_hist (
    .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid),
    .hist_mode(hist_mode), .entry(lk_entry), .key(lk_key)
  );

  exitp_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CYC_W(CYC_W)) u_tab (
    .clk(clk), .rst(rst), .flush(flush),
    .rd_en(lk_valid), .rd_key(lk_key),
    .wr_en(upd_valid), .wr_key(upd_key), .wr_target(upd_target),
    .wr_link(upd_link), .wr_cycle(upd_cycle), .wr_kind(upd_kind),
    .rd_hit(t_hit), .rd_target(t_target), .rd_link(t_link),
    .rd_cycle(t_cycle), .rd_kind(t_kind)
  );

  // stage 1: table read in flight
  always_ff @(posedge clk) begin
    if (rst || flush) s1_v <= 1'b0;
    else              s1_v <= lk_valid;
    if (lk_valid) s1_key <= lk_key;
  end

  // stage 2: decode and stack action
  always_comb begin
    mis     = upd_valid && upd_mispred;
    hit     = s1_v && t_hit && !mis && !flush;
    pv      = hit && ((t_kind != XK_RETURN) || (r_cnt != '0));
    s2_push = hit && (t_kind == XK_CALL);
    s2_pop  = hit && (t_kind == XK_RETURN);
    r_push  = mis ? (upd_kind == XK_CALL)   : s2_push;
    r_pop   = mis ? (upd_kind == XK_RETURN) : s2_pop;
    r_val   = mis ? upd_link : t_link;
  end

  exitp_ras #(.W(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk(clk), .rst(rst), .clear(flush),
    .push(r_push), .pop(r_pop), .push_val(r_val),
    .restore(mis), .snap_ptr(upd_snap_ptr), .snap_cnt(upd_snap_cnt),
    .top(r_top), .ptr(r_ptr), .cnt(r_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) pred_valid <= 1'b0;
    else              pred_valid <= pv;
    pred_target   <= (t_kind == XK_RETURN) ? r_top : t_target;
    pred_cycle    <= t_cycle;
    pred_kind     <= t_kind;
    pred_key      <= s1_key;
    pred_snap_ptr <= r_ptr;
    pred_snap_cnt <= r_cnt;
  end

  // R1
  flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !pred_valid);
  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> $past(lk_valid, 2));
  // R7
  ret_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    pred_valid && (pred_kind == XK_RETURN) |-> pred_snap_cnt != '0);
endmodule

// File: tb/sim_entry_exit_pred.sv
`timescale 1ns/1ps
module sim_entry_exit_pred;
  localparam int AW = 32, IW = 6, CW = 4, RD = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst, flush, lk_valid, hist_mode;
  logic [AW-1:0] lk_entry;
  logic          upd_valid, upd_mispred;
  logic [AW-1:0] upd_key, upd_target, upd_link;
  logic [CW-1:0] upd_cycle;
  logic [1:0]    upd_kind;
  logic [2:0]    upd_snap_ptr;
  logic [3:0]    upd_snap_cnt;
  logic          pred_valid;
  logic [AW-1:0] pred_target, pred_key;
  logic [CW-1:0] pred_cycle;
  logic [1:0]    pred_kind;
  logic [2:0]    pred_snap_ptr;
  logic [3:0]    pred_snap_cnt;

  entry_exit_pred u0 (
    .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid), .lk_entry(lk_entry),
    .hist_mode(hist_mode), .upd_valid(upd_valid), .upd_key(upd_key),
    .upd_target(upd_target), .upd_link(upd_link), .upd_cycle(upd_cycle),
    .upd_kind(upd_kind), .upd_mispred(upd_mispred), .upd_snap_ptr(upd_snap_ptr),
    .upd_snap_cnt(upd_snap_cnt), .pred_valid(pred_valid), .pred_target(pred_target),
    .pred_cycle(pred_cycle), .pred_kind(pred_kind), .pred_key(pred_key),
    .pred_snap_ptr(pred_snap_ptr), .pred_snap_cnt(pred_snap_cnt)
  );

  int    checks = 0, errors = 0, nvalid = 0;
  string cur_req = "R1";
  bit    done = 0;

  // behavioural reference
  bit            mv   [64];
  logic [AW-1:0] mkey [64];
  logic [AW-1:0] mtgt [64];
  logic [AW-1:0] mlink[64];
  logic [CW-1:0] mcyc [64];
  logic [1:0]    mknd [64];
  logic [AW-1:0] mh;
  logic [AW-1:0] mstk[$];
  bit            s1v, s1hit;
  logic [AW-1:0] s1tgt, s1link, s1key;
  logic [CW-1:0] s1cyc;
  logic [1:0]    s1knd;
  bit            ev;
  logic [AW-1:0] etgt, ekey;
  logic [CW-1:0] ecyc;
  logic [1:0]    eknd;
  logic [AW-1:0] esnap[$];
  logic [AW-1:0] rq[$];
  bit            cap_arm;
  logic [2:0]    cptr;
  logic [3:0]    ccnt;
  logic [AW-1:0] cq[$];

  task automatic model_step();
    bit mis;
    logic [AW-1:0] k, chain;
    int idx;
    if (rst || flush) begin
      foreach (mv[i]) mv[i] = 0;
      mh = '0; mstk.delete(); s1v = 0; ev = 0;
      return;
    end
    mis = upd_valid && upd_mispred;
    ev = 0;
    if (s1v && !mis && s1hit) begin
      esnap = mstk; ekey = s1key; ecyc = s1cyc; eknd = s1knd;
      if (s1knd == 2'd2) begin
        if (mstk.size() > 0) begin ev = 1; etgt = mstk[$]; void'(mstk.pop_back()); end
      end else begin
        ev = 1; etgt = s1tgt;
        if (s1knd == 2'd1) begin
          mstk.push_back(s1link);
          if (mstk.size() > RD) void'(mstk.pop_front());
        end
      end
    end
    if (mis) begin
      mstk = rq;
      if (upd_kind == 2'd1) begin
        mstk.push_back(upd_link);
        if (mstk.size() > RD) void'(mstk.pop_front());
      end else if (upd_kind == 2'd2 && mstk.size() > 0) void'(mstk.pop_back());
    end
    if (lk_valid) begin
      chain = lk_entry ^ (mh << 2);
      k = hist_mode ? chain : lk_entry;
      mh = chain;
      idx = int'(k % 64);
      s1hit = mv[idx] && (mkey[idx] == k);
      s1tgt = mtgt[idx]; s1link = mlink[idx]; s1cyc = mcyc[idx]; s1knd = mknd[idx];
      s1key = k;
    end
    s1v = lk_valid;
    if (upd_valid) begin
      idx = int'(upd_key % 64);
      mv[idx] = 1; mkey[idx] = upd_key; mtgt[idx] = upd_target;
      mlink[idx] = upd_link; mcyc[idx] = upd_cycle; mknd[idx] = upd_kind;
    end
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(cur_req, 64'(pred_valid), 64'(ev), "pred_valid");
    if (ev && pred_valid) begin
      chk(cur_req, 64'(pred_target), 64'(etgt), "pred_target");
      chk(cur_req, 64'(pred_cycle), 64'(ecyc), "pred_cycle");
      chk(cur_req, 64'(pred_kind), 64'(eknd), "pred_kind");
      chk(cur_req, 64'(pred_key), 64'(ekey), "pred_key");
    end
    if (pred_valid) nvalid++;
    if (cap_arm && ev) begin
      cap_arm = 0; cptr = pred_snap_ptr; ccnt = pred_snap_cnt; cq = esnap;
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    #1;
    compare();
    @(negedge clk);
    lk_valid = 0; upd_valid = 0; upd_mispred = 0; flush = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_upd(logic [AW-1:0] k, logic [AW-1:0] t, logic [AW-1:0] l,
                         logic [CW-1:0] c, logic [1:0] kd);
    upd_valid = 1; upd_key = k; upd_target = t; upd_link = l; upd_cycle = c; upd_kind = kd;
  endtask

  task automatic do_upd(logic [AW-1:0] k, logic [AW-1:0] t, logic [AW-1:0] l,
                        logic [CW-1:0] c, logic [1:0] kd);
    set_upd(k, t, l, c, kd);
    tick();
  endtask

  task automatic do_lk(logic [AW-1:0] e);
    lk_valid = 1; lk_entry = e;
    tick();
  endtask

  task automatic do_mis(logic [AW-1:0] k, logic [AW-1:0] t, logic [AW-1:0] l, logic [1:0] kd);
    set_upd(k, t, l, 4'd1, kd);
    upd_mispred = 1; upd_snap_ptr = cptr; upd_snap_cnt = ccnt; rq = cq;
    tick();
  endtask

  task automatic do_flush();
    flush = 1;
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    rst = 1; flush = 0; lk_valid = 0; hist_mode = 0; lk_entry = '0;
    upd_valid = 0; upd_mispred = 0; upd_key = '0; upd_target = '0; upd_link = '0;
    upd_cycle = '0; upd_kind = '0; upd_snap_ptr = '0; upd_snap_cnt = '0;
    cap_arm = 0; cptr = '0; ccnt = '0;
    @(negedge clk);
    // R1: reset state and empty table
    cur_req = "R1";
    idle(3);
    chk("R1", 64'(pred_valid), 64'd0, "valid in reset");
    rst = 0;
    do_lk(32'h0000_0100);
    idle(1);
    chk("R1", 64'(pred_valid), 64'd0, "valid after reset");

    // R2, R5: latency and branch fields
    cur_req = "R2";
    do_upd(32'h0000_0100, 32'h0000_2000, 32'h0, 4'd3, 2'd0);
    do_lk(32'h0000_0100);
    chk("R2", 64'(pred_valid), 64'd0, "after one edge");
    idle(1);
    chk("R2", 64'(pred_valid), 64'd1, "after two edges");
    chk("R5", 64'(pred_kind), 64'd0, "branch kind");
    chk("R5", 64'(pred_cycle), 64'd3, "exit cycle");

    // R3: alias in same slot, unwritten slot
    cur_req = "R3";
    do_lk(32'h0000_0140);
    do_lk(32'h0000_0105);
    chk("R3", 64'(pred_valid), 64'd0, "tag mismatch");
    idle(1);
    chk("R3", 64'(pred_valid), 64'd0, "unwritten slot");

    // R4: overwrite
    cur_req = "R4";
    do_upd(32'h0000_0100, 32'h0000_2100, 32'h0, 4'd7, 2'd0);
    do_lk(32'h0000_0100);
    idle(1);
    chk("R4", 64'(pred_target), 64'h2100, "newest target");

    // R11: same-cycle update and lookup
    cur_req = "R11";
    set_upd(32'h0000_0100, 32'h0000_2200, 32'h0, 4'd2, 2'd0);
    lk_valid = 1; lk_entry = 32'h0000_0100;
    tick();
    idle(1);
    chk("R11", 64'(pred_target), 64'h2100, "old contents seen");
    do_lk(32'h0000_0100);
    idle(1);
    chk("R11", 64'(pred_target), 64'h2200, "new contents later");

    // R6, R7: call then return
    cur_req = "R6";
    do_flush();
    do_upd(32'h0000_0308, 32'h0000_4010, 32'h0000_0304, 4'd5, 2'd1);
    do_upd(32'h0000_4010, 32'h0, 32'h0, 4'd9, 2'd2);
    do_lk(32'h0000_0308);
    idle(1);
    chk("R6", 64'(pred_kind), 64'd1, "call kind");
    cur_req = "R7";
    do_lk(32'h0000_4010);
    idle(1);
    chk("R7", 64'(pred_target), 64'h0304, "return from stack");
    do_lk(32'h0000_4010);
    idle(1);
    chk("R7", 64'(pred_valid), 64'd0, "empty stack");

    // R8: overflow keeps newest 8
    cur_req = "R8";
    do_flush();
    for (int i = 0; i < 9; i++)
      do_upd(32'h0000_0400 + 32'(i), 32'h0000_0520, 32'h0000_1000 + 32'(i), 4'd1, 2'd1);
    do_upd(32'h0000_0520, 32'h0, 32'h0, 4'd2, 2'd2);
    for (int i = 0; i < 9; i++) do_lk(32'h0000_0400 + 32'(i));
    idle(2);
    nvalid = 0;
    do_lk(32'h0000_0520);
    idle(1);
    chk("R8", 64'(pred_target), 64'h1008, "newest first");
    for (int i = 0; i < 8; i++) do_lk(32'h0000_0520);
    idle(2);
    chk("R8", 64'(nvalid), 64'd8, "returns predicted");

    // R9: history chain
    cur_req = "R9";
    do_flush();
    hist_mode = 1;
    do_upd(32'h0000_0120, 32'h0000_7770, 32'h0, 4'd4, 2'd0);
    do_lk(32'h0000_0050);
    do_lk(32'h0000_0060);
    idle(1);
    chk("R9", 64'(pred_valid), 64'd1, "chained hit");
    chk("R9", 64'(pred_key), 64'h0120, "chained key");
    do_flush();
    do_upd(32'h0000_0120, 32'h0000_7770, 32'h0, 4'd4, 2'd0);
    do_lk(32'h0000_0060);
    idle(1);
    chk("R9", 64'(pred_valid), 64'd0, "history cleared");
    hist_mode = 0;

    // R10: restore on misprediction
    cur_req = "R10";
    do_flush();
    do_upd(32'h0000_0308, 32'h0000_4010, 32'h0000_0304, 4'd5, 2'd1);
    do_upd(32'h0000_4010, 32'h0, 32'h0, 4'd9, 2'd2);
    cap_arm = 1;
    do_lk(32'h0000_0308);
    idle(1);
    do_mis(32'h0000_0308, 32'h0000_0600, 32'h0, 2'd0);
    do_lk(32'h0000_4010);
    idle(1);
    chk("R10", 64'(pred_valid), 64'd0, "push undone");
    do_upd(32'h0000_0308, 32'h0000_4010, 32'h0000_0304, 4'd5, 2'd1);
    cap_arm = 1;
    do_lk(32'h0000_0308);
    idle(1);
    do_mis(32'h0000_0308, 32'h0000_4010, 32'h0000_0999, 2'd1);
    do_lk(32'h0000_4010);
    idle(1);
    chk("R10", 64'(pred_target), 64'h0999, "corrected push");
    do_lk(32'h0000_4010);
    do_mis(32'h0000_0308, 32'h0000_4010, 32'h0000_0999, 2'd1);
    chk("R10", 64'(pred_valid), 64'd0, "in-flight squashed");
    idle(2);

    // R1: flush drops same-cycle update
    cur_req = "R1";
    flush = 1;
    set_upd(32'h0000_0200, 32'h0000_0a00, 32'h0, 4'd1, 2'd0);
    tick();
    do_lk(32'h0000_0200);
    idle(1);
    chk("R1", 64'(pred_valid), 64'd0, "update in flush dropped");

    finish_run();
  end
endmodule